// File: doc/BRIEF.md
# Multi-Chain Scan Register with Stuck-At Fault Injection

This block is a small sequential circuit built so that every storage element can be reached from outside. Each flip-flop is a mux-D scan cell. A single mode input chooses what each cell loads on a clock edge. In shift mode each cell takes its upstream neighbour's value. In capture mode each cell takes the output of a combinational logic cloud that is computed from the present register contents.

The cells are grouped into several equal-length chains. Each chain has its own serial input and serial output, so a full state image loads and unloads in as many cycles as one chain has cells. The logic cloud splits the register into two halves. One half receives the sum of the two halves and the other receives a bitwise mix of them.

A fault injector sits between the cloud and the cells. It can pin any one cloud output node to a constant 0 or a constant 1. A test sequence can therefore show that a chosen pattern tells the good circuit from the faulty one. The usual sequence is: shift a pattern in, hold the mode input low for one capture cycle, then shift the result out while the next pattern shifts in.

Top module: `scan_fault_core`

## Requirements
- R1: While reset is asserted, and after it is released, every cell holds 0 and every scan output reads 0 until a cell is loaded.
- R2: With scan_enable high, on each clock edge cell 0 of chain c takes scan_in[c], cell p takes the old value of cell p-1, and scan_out[c] shows cell CHAIN_LEN-1. The chains shift independently of one another.
- R3: Exactly CHAIN_LEN shift cycles load a full state image. Register bit c*CHAIN_LEN+p is cell p of chain c. The bit presented at shift number t (counting from 0) ends in cell CHAIN_LEN-1-t.
- R4: In a capture cycle with no fault, register bits [H-1:0] take (A + B) mod 2^H. Here H is half the register width, A is bits [H-1:0] and B is bits [2H-1:H].
- R5: In a capture cycle with no fault, register bit H+k takes A[k] XOR B[(k-1) mod H], for k from 0 to H-1.
- R6: In a capture cycle with fault_en high, the cloud node whose index is fault_node is stuck at fault_val (0 means stuck-at-0, 1 means stuck-at-1). Every other node captures its fault-free value.
- R7: With fault_en low, fault_val and fault_node have no effect on captured values.
- R8: While scan_enable is high, fault injection has no effect: the shifted data passes unchanged.
- R9: Unloading a captured image and loading the next image take place in the same CHAIN_LEN shift cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_enable | input | 1 | 1 = shift mode, 0 = capture mode |
| scan_in | input | NUM_CHAINS | Serial input of each chain |
| fault_en | input | 1 | Enables the stuck-at fault |
| fault_val | input | 1 | Stuck value: 0 = stuck-at-0, 1 = stuck-at-1 |
| fault_node | input | $clog2(NUM_CHAINS*CHAIN_LEN) | Index of the cloud node to force |
| scan_out | output | NUM_CHAINS | Last cell of each chain |

## Verification
On every cycle the assertions check the serial step of each chain, the reset-clear state, and that a capture cycle loads the cloud output. They also check that an injected fault pins exactly the chosen node and leaves every other node alone. Only the bench scenarios can show that the cloud computes the intended sum and mixed halves, that the mapping of serial order to register bit is the one stated, and that a full image round-trips through the chains. They also show that a fault changes the unloaded result for every node and for both polarities.

// File: rtl/scan_fault_pkg.sv
package scan_fault_pkg;
  localparam int unsigned DEF_CHAINS = 4;
  localparam int unsigned DEF_LEN    = 8;

  typedef enum logic {
    STUCK_AT_0 = 1'b0,
    STUCK_AT_1 = 1'b1
  } stuck_t;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_SHIFT   = 1'b1
  } scan_mode_t;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;
  logic meta_d;
  logic out_d;

  always_comb begin
    meta_d = 1'b1;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= meta_d;
      rst_q_n <= out_d;
    end
  end
endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import scan_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic si,
  input  logic d,
  output logic q
);
  scan_mode_t mode;
  logic       q_next;

  always_comb begin
    mode   = scan_mode_t'(se);
    q_next = (mode == MODE_SHIFT) ? si : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           se,
  input  logic           si,
  input  logic [LEN-1:0] d,
  output logic [LEN-1:0] q,
  output logic           so
);
  logic [LEN-1:0] link;

  assign link[0] = si;

  for (genvar p = 1; p < LEN; p++) begin : g_link
    assign link[p] = q[p-1];
  end

  for (genvar p = 0; p < LEN; p++) begin : g_cell
    scan_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .se   (se),
      .si   (link[p]),
      .d    (d[p]),
      .q    (q[p])
    );
  end

  assign so = q[LEN-1];
endmodule

// File: rtl/scan_logic_cloud.sv
module scan_logic_cloud #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [HALF-1:0] op_a;
  logic [HALF-1:0] op_b;
  logic [HALF-1:0] op_b_rot;
  logic [HALF-1:0] sum_lo;
  logic [HALF-1:0] mix_hi;

  always_comb begin
    op_a     = cur[HALF-1:0];
    op_b     = cur[2*HALF-1:HALF];
    op_b_rot = {op_b[HALF-2:0], op_b[HALF-1]};
    sum_lo   = op_a + op_b;
    mix_hi   = op_a ^ op_b_rot;
    nxt      = '0;
    nxt[HALF-1:0]      = sum_lo;
    nxt[2*HALF-1:HALF] = mix_hi;
  end
endmodule

// File: rtl/scan_fault_inject.sv
module scan_fault_inject
  import scan_fault_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] node_in,
  input  logic             enable,
  input  logic             value,
  input  logic [IDX_W-1:0] node_sel,
  output logic [WIDTH-1:0] node_out
);
  stuck_t polarity;

  assign polarity = stuck_t'(value);

  for (genvar k = 0; k < WIDTH; k++) begin : g_node
    logic hit;
    always_comb begin
      hit         = enable && (node_sel == IDX_W'(k));
      node_out[k] = hit ? (polarity == STUCK_AT_1) : node_in[k];
    end
  end
endmodule

// File: rtl/scan_fault_core.sv
module scan_fault_core
  import scan_fault_pkg::*;
#(
  parameter int unsigned NUM_CHAINS = DEF_CHAINS,
  parameter int unsigned CHAIN_LEN  = DEF_LEN,
  localparam int unsigned WIDTH = NUM_CHAINS * CHAIN_LEN,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_enable,
  input  logic [NUM_CHAINS-1:0] scan_in,
  input  logic                  fault_en,
  input  logic                  fault_val,
  input  logic [IDX_W-1:0]      fault_node,
  output logic [NUM_CHAINS-1:0] scan_out
);
  logic             rst_q_n;
  logic [WIDTH-1:0] cells;
  logic [WIDTH-1:0] cloud_raw;
  logic [WIDTH-1:0] cloud_fx;

  scan_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  scan_logic_cloud #(.WIDTH(WIDTH)) u_cloud (
    .cur(cells),
    .nxt(cloud_raw)
  );

  scan_fault_inject #(.WIDTH(WIDTH)) u_fault (
    .node_in (cloud_raw),
    .enable  (fault_en),
    .value   (fault_val),
    .node_sel(fault_node),
    .node_out(cloud_fx)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    scan_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk  (clk),
      .rst_n(rst_q_n),
      .se   (scan_enable),
      .si   (scan_in[c]),
      .d    (cloud_fx[c*CHAIN_LEN +: CHAIN_LEN]),
      .q    (cells[c*CHAIN_LEN +: CHAIN_LEN]),
      .so   (scan_out[c])
    );
  end
endmodule

// File: rtl/scan_fault_chk.sv
module scan_fault_chk #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CHAIN_LEN  = 8,
  localparam int unsigned WIDTH = NUM_CHAINS * CHAIN_LEN,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic                  scan_enable,
  input logic [NUM_CHAINS-1:0] scan_in,
  input logic [NUM_CHAINS-1:0] scan_out,
  input logic                  fault_en,
  input logic                  fault_val,
  input logic [IDX_W-1:0]      fault_node,
  input logic [WIDTH-1:0]      cells,
  input logic [WIDTH-1:0]      cloud_raw
);
  logic [WIDTH-1:0] sel_mask;
  assign sel_mask = WIDTH'(1) << fault_node;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_q_n |-> (cells == '0 && scan_out == '0));

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain_chk
    // R2
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      scan_enable |=> cells[c*CHAIN_LEN] == $past(scan_in[c]));
    // R2
    tail_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      scan_enable |=> scan_out[c] == $past(cells[c*CHAIN_LEN+CHAIN_LEN-2]));
  end

  // R4 R5 R7
  clean_capture_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!scan_enable && !fault_en) |=> cells == $past(cloud_raw));

  // R6
  others_intact_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!scan_enable && fault_en) |=>
      ((cells ^ $past(cloud_raw)) & ~$past(sel_mask)) == '0);

  for (genvar k = 0; k < WIDTH; k++) begin : g_node_chk
    // R6
    stuck_node_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (!scan_enable && fault_en && fault_node == IDX_W'(k)) |=>
        cells[k] == $past(fault_val));
  end
endmodule

bind scan_fault_core scan_fault_chk #(
  .NUM_CHAINS(NUM_CHAINS),
  .CHAIN_LEN (CHAIN_LEN)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .scan_enable(scan_enable),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .fault_en   (fault_en),
  .fault_val  (fault_val),
  .fault_node (fault_node),
  .cells      (cells),
  .cloud_raw  (cloud_raw)
);

// File: tb/scan_fault_core_test.sv
module scan_fault_core_test;
  localparam int C = 4;
  localparam int L = 8;
  localparam int N = C * L;
  localparam int H = N / 2;
  localparam int IW = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic          scan_enable;
  logic [C-1:0]  scan_in;
  logic          fault_en;
  logic          fault_val;
  logic [IW-1:0] fault_node;
  logic [C-1:0]  scan_out;

  int n_cmp;
  int n_bad;
  logic [31:0] seed;

  scan_fault_core #(.NUM_CHAINS(C), .CHAIN_LEN(L)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_enable(scan_enable),
    .scan_in    (scan_in),
    .fault_en   (fault_en),
    .fault_val  (fault_val),
    .fault_node (fault_node),
    .scan_out   (scan_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [N-1:0] model(input logic [N-1:0] s);
    logic [H-1:0] a, b, lo, hi;
    a  = s[H-1:0];
    b  = s[N-1:H];
    lo = H'((a + b) % (64'd1 << H));
    for (int k = 0; k < H; k++) hi[k] = a[k] ^ b[(k + H - 1) % H];
    return {hi, lo};
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_unload(input logic [N-1:0] nxt, output logic [N-1:0] old);
    for (int t = 0; t < L; t++) begin
      for (int c = 0; c < C; c++) begin
        old[c*L + L-1-t] = scan_out[c];
        scan_in[c]       = nxt[c*L + L-1-t];
      end
      scan_enable = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    scan_in = '0;
  endtask

  task automatic capture(input logic fe, input logic fv, input logic [IW-1:0] fn);
    scan_enable = 1'b0;
    fault_en    = fe;
    fault_val   = fv;
    fault_node  = fn;
    @(posedge clk);
    @(negedge clk);
    fault_en    = 1'b0;
    scan_enable = 1'b1;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] s, got, exp, junk;
    n_cmp = 0; n_bad = 0; seed = 32'h1234_5678;
    scan_enable = 1'b1; scan_in = '0;
    fault_en = 1'b0; fault_val = 1'b0; fault_node = '0;
    rst_n = 1'b0;
    @(negedge clk);
    apply_reset();

    // R1: outputs and full image are zero after reset
    check("R1", N'(scan_out), '0);
    load_unload(32'hA5C3_0F96, got);
    check("R1", got, '0);

    // R2 R3 R9: round trip of distinct per-chain images, exactly L shifts
    load_unload(32'h0123_4567, got);
    check("R3", got, 32'hA5C3_0F96);
    load_unload(32'hFF00_00FF, got);
    check("R9", got, 32'h0123_4567);
    // R2: one extra shift moves each chain by one cell
    load_unload(32'h0000_0000, got);
    check("R2", got, 32'hFF00_00FF);
    load_unload(32'h8000_0001, junk);
    scan_in = 4'b1111;
    scan_enable = 1'b1;
    @(posedge clk); @(negedge clk);
    scan_in = '0;
    load_unload('0, got);
    check("R2", got, {32'h8000_0001 << 1} & ~32'h0101_0101 | 32'h0101_0101);

    // R4 R5: fault-free captures over corners and pseudo-random images
    for (int i = 0; i < 28; i++) begin
      case (i)
        0: s = '0;
        1: s = '1;
        2: s = 32'h0000_FFFF;
        3: s = 32'hFFFF_0001;
        default: begin seed = lcg(seed); s = seed; end
      endcase
      load_unload(s, junk);
      capture(1'b0, 1'b0, '0);
      load_unload('0, got);
      exp = model(s);
      check("R4", {{H{1'b0}}, got[H-1:0]}, {{H{1'b0}}, exp[H-1:0]});
      check("R5", {got[N-1:H], {H{1'b0}}}, {exp[N-1:H], {H{1'b0}}});
    end

    // R7: fault controls set but disabled
    for (int i = 0; i < 8; i++) begin
      seed = lcg(seed); s = seed;
      load_unload(s, junk);
      capture(1'b0, i[0], IW'(i * 5));
      load_unload('0, got);
      check("R7", got, model(s));
    end

    // R6: every node, both polarities
    for (int k = 0; k < N; k++) begin
      for (int v = 0; v < 2; v++) begin
        seed = lcg(seed); s = seed;
        load_unload(s, junk);
        capture(1'b1, v[0], IW'(k));
        load_unload('0, got);
        exp = model(s);
        exp[k] = v[0];
        check("R6", got, exp);
      end
    end

    // R8: fault enabled during shifting has no effect
    for (int i = 0; i < 4; i++) begin
      seed = lcg(seed); s = seed;
      fault_en = 1'b1; fault_val = i[0]; fault_node = IW'(i * 7 + 3);
      load_unload(s, junk);
      load_unload('0, got);
      fault_en = 1'b0;
      check("R8", got, s);
    end

    // R1: reset after a nonzero load clears the image
    load_unload(32'hDEAD_BEEF, junk);
    apply_reset();
    check("R1", N'(scan_out), '0);
    load_unload('0, got);
    check("R1", got, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule